// File: doc/BRIEF.md
# MDIO PHY Presence Scan Engine

This block sits in front of a single MDIO frame engine and keeps it busy with two kinds of traffic. While scanning is enabled, it polls the PHY addresses in turn with a read of the basic status register. From each result it keeps one presence bit and one link bit per address, and a sticky change flag per address that can be masked. Software-side user commands arrive on a valid/ready request port. They share the same frame engine, and the block arbitrates so that a waiting user command is delayed by at most the frame already on the wire.

The frame engine itself, meaning the serialisation of preamble, opcode, addresses and turnaround, lives outside this block. It takes one command on a valid/ready request channel. It reports completion with a single-cycle `fe_done` pulse that carries the acknowledge flag and the read data. The user response is a single-cycle `usr_rsp_valid` pulse with no back-pressure. The requester must accept it in the cycle it appears. On the request side, `usr_ready` is high only while no frame is in progress. Once the block raises `fe_req_valid`, the command fields on the frame-engine request stay fixed until `fe_req_ready` is seen.

Top module: `mdio_scan_engine`

## Requirements
- R1: After reset, the presence, link and change-flag vectors are all zero, `scan_idle` is 1 and no frame request is raised.
- R2: Each scan frame is a read (`fe_req_write`=0) of register address 1. Addresses are polled in ascending order from 0 to NUM_PHY-1 and then wrap to 0. A request holds its fields stable until `fe_req_ready`.
- R3: When a scan frame completes with acknowledge, the presence bit of that address is set to 1.
- R4: When a scan frame completes with acknowledge, the link bit of that address takes bit 2 of the returned data.
- R5: A scan frame that completes without acknowledge clears both the presence bit and the link bit of that address.
- R6: A pending user command always wins over the next scan frame. `usr_ready` is high exactly when no frame is in progress, so a user command waits for at most one frame.
- R7: After a user command, scanning resumes at the address following the last address scanned.
- R8: A change flag bit sets whenever a scan completion changes the link bit of its address.
- R9: A change flag bit is cleared by a 1 on the matching bit of `link_irq_clr`. A set in the same cycle takes precedence over the clear.
- R10: `link_irq_masked` equals the change flags ANDed with `link_irq_en`.
- R11: While `scan_enable` is 0, no new scan frame starts. `scan_idle` rises once the frame in progress completes.
- R12: A user command completes with one `usr_rsp_valid` pulse in the cycle of `fe_done`, carrying the frame engine's acknowledge and read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_enable | input | 1 | Allows scan frames to start |
| scan_idle | output | 1 | No frame in progress |
| usr_valid | input | 1 | User command valid |
| usr_ready | output | 1 | User command accepted this cycle when valid |
| usr_write | input | 1 | 1 = write, 0 = read |
| usr_phy | input | 5 | User PHY address |
| usr_reg | input | 5 | User register address |
| usr_wdata | input | 16 | User write data |
| usr_rsp_valid | output | 1 | User command completed (one-cycle pulse) |
| usr_rsp_ack | output | 1 | PHY acknowledged the user command |
| usr_rsp_rdata | output | 16 | Read data of the user command |
| fe_req_valid | output | 1 | Frame request valid |
| fe_req_ready | input | 1 | Frame engine accepts the request |
| fe_req_write | output | 1 | Frame is a write |
| fe_req_phy | output | 5 | Frame PHY address |
| fe_req_reg | output | 5 | Frame register address |
| fe_req_wdata | output | 16 | Frame write data |
| fe_done | input | 1 | Frame completed (one-cycle pulse) |
| fe_ack | input | 1 | PHY acknowledged the frame |
| fe_rdata | input | 16 | Frame read data |
| alive_mask | output | NUM_PHY | Per-address presence bits |
| link_mask | output | NUM_PHY | Per-address link bits |
| link_irq_raw | output | NUM_PHY | Sticky per-address link-change flags |
| link_irq_en | input | NUM_PHY | Per-address flag enables |
| link_irq_clr | input | NUM_PHY | Write-1-to-clear strobes for the flags |
| link_irq_masked | output | NUM_PHY | Flags ANDed with enables |

## Verification
The bench builds the block with NUM_PHY=4, so that a full scan round takes only a few dozen cycles. Within one run this covers several wraps of the address counter, presence loss on address 0 and a link drop on the top address. It keeps the default status register 1 and link bit 2. Its frame-engine model answers with a three-cycle latency and withholds ready every third cycle. User commands therefore collide with scan frames in all of their phases, including a request stalled by back-pressure.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;
  localparam int MDIO_ADDR_W = 5;
  localparam int MDIO_DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } scan_st_e;

  typedef struct packed {
    logic                   wr;
    logic [MDIO_ADDR_W-1:0] phy;
    logic [MDIO_ADDR_W-1:0] regad;
    logic [MDIO_DATA_W-1:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_scan_arbiter.sv
module mdio_scan_arbiter
  import mdio_scan_pkg::*;
#(
  parameter int NUM_PHY    = 32,
  parameter int STATUS_REG = 1,
  localparam int PTR_W     = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             usr_valid,
  input  mdio_cmd_t        usr_cmd,
  output logic             usr_ready,
  output logic             fe_req_valid,
  input  logic             fe_req_ready,
  output mdio_cmd_t        fe_cmd,
  input  logic             fe_done,
  output logic             idle,
  output logic             scan_done,
  output logic [PTR_W-1:0] scan_addr,
  output logic             user_done
);
  scan_st_e         st_q;
  logic             own_user_q;
  mdio_cmd_t        cmd_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_nxt;

  // next address with wrap at NUM_PHY-1
  assign ptr_nxt = (ptr_q == PTR_W'(NUM_PHY - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      own_user_q <= 1'b0;
      cmd_q      <= '0;
      ptr_q      <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (usr_valid) begin
            cmd_q      <= usr_cmd;
            own_user_q <= 1'b1;
            st_q       <= ST_ISSUE;
          end else if (enable) begin
            cmd_q.wr    <= 1'b0;
            cmd_q.phy   <= MDIO_ADDR_W'(ptr_q);
            cmd_q.regad <= MDIO_ADDR_W'(STATUS_REG);
            cmd_q.wdata <= '0;
            own_user_q  <= 1'b0;
            st_q        <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (fe_req_ready) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (fe_done) begin
            st_q <= ST_IDLE;
            if (!own_user_q) ptr_q <= ptr_nxt;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle         = (st_q == ST_IDLE);
  assign usr_ready    = idle;
  assign fe_req_valid = (st_q == ST_ISSUE);
  assign fe_cmd       = cmd_q;
  assign scan_done    = (st_q == ST_WAIT) && fe_done && !own_user_q;
  assign user_done    = (st_q == ST_WAIT) && fe_done && own_user_q;
  assign scan_addr    = cmd_q.phy[PTR_W-1:0];
endmodule

// File: rtl/mdio_scan_status.sv
module mdio_scan_status
  import mdio_scan_pkg::*;
#(
  parameter int NUM_PHY  = 32,
  parameter int LINK_BIT = 2,
  localparam int PTR_W   = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_valid,
  input  logic [PTR_W-1:0]       upd_addr,
  input  logic                   upd_ack,
  input  logic [MDIO_DATA_W-1:0] upd_rdata,
  input  logic [NUM_PHY-1:0]     irq_clr,
  input  logic [NUM_PHY-1:0]     irq_en,
  output logic [NUM_PHY-1:0]     alive,
  output logic [NUM_PHY-1:0]     link,
  output logic [NUM_PHY-1:0]     raw,
  output logic [NUM_PHY-1:0]     masked
);
  logic new_link;
  assign new_link = upd_ack & upd_rdata[LINK_BIT];

  for (genvar i = 0; i < NUM_PHY; i++) begin : g_phy
    logic hit;
    assign hit = upd_valid && (upd_addr == PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alive[i] <= 1'b0;
        link[i]  <= 1'b0;
        raw[i]   <= 1'b0;
      end else begin
        if (hit) begin
          alive[i] <= upd_ack;
          link[i]  <= new_link;
        end
        // a fresh change outranks a clear strobe in the same cycle
        raw[i] <= (hit && (new_link != link[i])) | (raw[i] & ~irq_clr[i]);
      end
    end
  end

  assign masked = raw & irq_en;
endmodule

// File: rtl/mdio_scan_engine.sv
module mdio_scan_engine
  import mdio_scan_pkg::*;
#(
  parameter int NUM_PHY    = 32,
  parameter int STATUS_REG = 1,
  parameter int LINK_BIT   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_enable,
  output logic               scan_idle,
  input  logic               usr_valid,
  output logic               usr_ready,
  input  logic               usr_write,
  input  logic [4:0]         usr_phy,
  input  logic [4:0]         usr_reg,
  input  logic [15:0]        usr_wdata,
  output logic               usr_rsp_valid,
  output logic               usr_rsp_ack,
  output logic [15:0]        usr_rsp_rdata,
  output logic               fe_req_valid,
  input  logic               fe_req_ready,
  output logic               fe_req_write,
  output logic [4:0]         fe_req_phy,
  output logic [4:0]         fe_req_reg,
  output logic [15:0]        fe_req_wdata,
  input  logic               fe_done,
  input  logic               fe_ack,
  input  logic [15:0]        fe_rdata,
  output logic [NUM_PHY-1:0] alive_mask,
  output logic [NUM_PHY-1:0] link_mask,
  output logic [NUM_PHY-1:0] link_irq_raw,
  input  logic [NUM_PHY-1:0] link_irq_en,
  input  logic [NUM_PHY-1:0] link_irq_clr,
  output logic [NUM_PHY-1:0] link_irq_masked
);
  localparam int PTR_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;

  mdio_cmd_t        usr_cmd;
  mdio_cmd_t        fe_cmd;
  logic             scan_done;
  logic             user_done;
  logic [PTR_W-1:0] scan_addr;

  assign usr_cmd = '{wr: usr_write, phy: usr_phy, regad: usr_reg, wdata: usr_wdata};

  mdio_scan_arbiter #(
    .NUM_PHY    (NUM_PHY),
    .STATUS_REG (STATUS_REG)
  ) arb_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (scan_enable),
    .usr_valid    (usr_valid),
    .usr_cmd      (usr_cmd),
    .usr_ready    (usr_ready),
    .fe_req_valid (fe_req_valid),
    .fe_req_ready (fe_req_ready),
    .fe_cmd       (fe_cmd),
    .fe_done      (fe_done),
    .idle         (scan_idle),
    .scan_done    (scan_done),
    .scan_addr    (scan_addr),
    .user_done    (user_done)
  );

  mdio_scan_status #(
    .NUM_PHY  (NUM_PHY),
    .LINK_BIT (LINK_BIT)
  ) stat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (scan_done),
    .upd_addr  (scan_addr),
    .upd_ack   (fe_ack),
    .upd_rdata (fe_rdata),
    .irq_clr   (link_irq_clr),
    .irq_en    (link_irq_en),
    .alive     (alive_mask),
    .link      (link_mask),
    .raw       (link_irq_raw),
    .masked    (link_irq_masked)
  );

  assign fe_req_write  = fe_cmd.wr;
  assign fe_req_phy    = fe_cmd.phy;
  assign fe_req_reg    = fe_cmd.regad;
  assign fe_req_wdata  = fe_cmd.wdata;
  assign usr_rsp_valid = user_done;
  assign usr_rsp_ack   = fe_ack;
  assign usr_rsp_rdata = fe_rdata;
endmodule

// File: rtl/mdio_scan_engine_chk.sv
module mdio_scan_engine_chk #(
  parameter int NUM_PHY    = 32,
  parameter int STATUS_REG = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_enable,
  input logic               scan_idle,
  input logic               usr_valid,
  input logic               usr_write,
  input logic [4:0]         usr_phy,
  input logic               usr_rsp_valid,
  input logic               fe_req_valid,
  input logic               fe_req_ready,
  input logic               fe_req_write,
  input logic [4:0]         fe_req_phy,
  input logic [4:0]         fe_req_reg,
  input logic               fe_done,
  input logic [NUM_PHY-1:0] link_irq_raw,
  input logic [NUM_PHY-1:0] link_irq_clr
);
  AST_USER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_idle && usr_valid) |=> (fe_req_valid && fe_req_phy == $past(usr_phy) && fe_req_write == $past(usr_write))); // R6

  AST_SCAN_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_idle && !usr_valid && scan_enable) |=> (fe_req_valid && !fe_req_write && fe_req_reg == 5'(STATUS_REG))); // R2

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_req_valid && !fe_req_ready) |=> (fe_req_valid && $stable(fe_req_phy) && $stable(fe_req_reg))); // R2

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_idle && !usr_valid && !scan_enable) |=> scan_idle); // R11

  AST_RSP_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    usr_rsp_valid |-> (fe_done && !scan_idle)); // R12

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((link_irq_raw & $past(link_irq_raw & ~link_irq_clr)) == $past(link_irq_raw & ~link_irq_clr))); // R9
endmodule

bind mdio_scan_engine mdio_scan_engine_chk #(
  .NUM_PHY    (NUM_PHY),
  .STATUS_REG (STATUS_REG)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .scan_enable   (scan_enable),
  .scan_idle     (scan_idle),
  .usr_valid     (usr_valid),
  .usr_write     (usr_write),
  .usr_phy       (usr_phy),
  .usr_rsp_valid (usr_rsp_valid),
  .fe_req_valid  (fe_req_valid),
  .fe_req_ready  (fe_req_ready),
  .fe_req_write  (fe_req_write),
  .fe_req_phy    (fe_req_phy),
  .fe_req_reg    (fe_req_reg),
  .fe_done       (fe_done),
  .link_irq_raw  (link_irq_raw),
  .link_irq_clr  (link_irq_clr)
);

// File: tb/mdio_scan_engine_tb_top.sv
module mdio_scan_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPHY       = 4;
  localparam int LAT        = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_enable = 1'b0;
  logic scan_idle;
  logic usr_valid = 1'b0;
  logic usr_ready;
  logic usr_write = 1'b0;
  logic [4:0] usr_phy = '0;
  logic [4:0] usr_reg = '0;
  logic [15:0] usr_wdata = '0;
  logic usr_rsp_valid, usr_rsp_ack;
  logic [15:0] usr_rsp_rdata;
  logic fe_req_valid;
  logic fe_req_ready = 1'b1;
  logic fe_req_write;
  logic [4:0] fe_req_phy, fe_req_reg;
  logic [15:0] fe_req_wdata;
  logic fe_done = 1'b0;
  logic fe_ack = 1'b0;
  logic [15:0] fe_rdata = '0;
  logic [NPHY-1:0] alive_mask, link_mask, link_irq_raw, link_irq_masked;
  logic [NPHY-1:0] link_irq_en = '0;
  logic [NPHY-1:0] link_irq_clr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_scan_engine #(.NUM_PHY(NPHY), .STATUS_REG(1), .LINK_BIT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_enable(scan_enable), .scan_idle(scan_idle),
    .usr_valid(usr_valid), .usr_ready(usr_ready), .usr_write(usr_write),
    .usr_phy(usr_phy), .usr_reg(usr_reg), .usr_wdata(usr_wdata),
    .usr_rsp_valid(usr_rsp_valid), .usr_rsp_ack(usr_rsp_ack), .usr_rsp_rdata(usr_rsp_rdata),
    .fe_req_valid(fe_req_valid), .fe_req_ready(fe_req_ready), .fe_req_write(fe_req_write),
    .fe_req_phy(fe_req_phy), .fe_req_reg(fe_req_reg), .fe_req_wdata(fe_req_wdata),
    .fe_done(fe_done), .fe_ack(fe_ack), .fe_rdata(fe_rdata),
    .alive_mask(alive_mask), .link_mask(link_mask), .link_irq_raw(link_irq_raw),
    .link_irq_en(link_irq_en), .link_irq_clr(link_irq_clr), .link_irq_masked(link_irq_masked)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // PHY population seen by the frame-engine model
  logic [NPHY-1:0] present = 4'b1101;
  logic [NPHY-1:0] link_up = 4'b1001;

  // reference model state
  int m_st = 0;          // 0 idle, 1 issuing, 2 waiting
  bit m_user = 0;
  bit m_after_user = 0;
  int m_ptr = 0;
  logic [4:0] m_phy, m_reg;
  logic m_wr;
  logic [15:0] m_wd;
  logic [NPHY-1:0] m_alive = '0, m_link = '0, m_raw = '0;
  int rsp_cnt = 0;
  logic [4:0] rsp_phy, rsp_reg;
  int rsp_seen = 0;
  logic [15:0] last_rdata;
  logic last_ack;
  int cyc = 0;

  task automatic model_eval();
    logic [NPHY-1:0] setv;
    logic nl;
    int a;
    if (!rst_n) begin
      m_st = 0; m_user = 0; m_ptr = 0; m_after_user = 0;
      m_alive = '0; m_link = '0; m_raw = '0; rsp_cnt = 0;
      return;
    end
    check(alive_mask == m_alive, "R3 alive_mask", 32'(alive_mask), 32'(m_alive));
    check(link_mask == m_link, "R4 link_mask", 32'(link_mask), 32'(m_link));
    check(link_irq_raw == m_raw, "R8 link_irq_raw", 32'(link_irq_raw), 32'(m_raw));
    check(link_irq_masked == (m_raw & link_irq_en), "R10 link_irq_masked",
          32'(link_irq_masked), 32'(m_raw & link_irq_en));
    check(usr_ready == (m_st == 0), "R6 usr_ready", 32'(usr_ready), 32'(m_st == 0));
    check(scan_idle == (m_st == 0), "R11 scan_idle", 32'(scan_idle), 32'(m_st == 0));
    check(fe_req_valid == (m_st == 1), "R2 fe_req_valid", 32'(fe_req_valid), 32'(m_st == 1));
    check(usr_rsp_valid == (m_st == 2 && m_user && fe_done), "R12 usr_rsp_valid",
          32'(usr_rsp_valid), 32'(m_st == 2 && m_user && fe_done));
    if (m_st == 1) begin
      if (m_user)
        check(fe_req_phy == m_phy && fe_req_reg == m_reg && fe_req_write == m_wr &&
              (!m_wr || fe_req_wdata == m_wd), "R6 user frame fields",
              {fe_req_write, fe_req_phy, fe_req_reg}, {m_wr, m_phy, m_reg});
      else
        check(fe_req_phy == m_phy && fe_req_reg == 5'd1 && !fe_req_write,
              m_after_user ? "R7 scan resume fields" : "R2 scan frame fields",
              {fe_req_write, fe_req_phy, fe_req_reg}, {1'b0, m_phy, 5'd1});
    end
    setv = '0;
    case (m_st)
      0: begin
        if (usr_valid) begin
          m_user = 1; m_phy = usr_phy; m_reg = usr_reg; m_wr = usr_write; m_wd = usr_wdata; m_st = 1;
        end else if (scan_enable) begin
          m_user = 0; m_phy = 5'(m_ptr); m_reg = 5'd1; m_wr = 0; m_wd = '0; m_st = 1;
        end
      end
      1: if (fe_req_ready) begin
        rsp_cnt = LAT; rsp_phy = m_phy; rsp_reg = m_reg; m_st = 2;
      end
      default: if (fe_done) begin
        m_st = 0;
        if (m_user) begin
          check(usr_rsp_ack == fe_ack && usr_rsp_rdata == fe_rdata, "R12 response payload",
                {usr_rsp_ack, usr_rsp_rdata}, {fe_ack, fe_rdata});
          last_rdata = usr_rsp_rdata; last_ack = usr_rsp_ack; rsp_seen++;
          m_after_user = 1;
        end else begin
          a = int'(m_phy);
          nl = fe_ack & fe_rdata[2];
          if (nl != m_link[a]) setv[a] = 1'b1;
          m_alive[a] = fe_ack;
          m_link[a] = nl;
          m_ptr = (m_ptr + 1) % NPHY;
          m_after_user = 0;
        end
      end
    endcase
    m_raw = (m_raw & ~link_irq_clr) | setv;
  endtask

  // frame-engine model plus reference model, stepped each cycle
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      fe_req_ready = (cyc % 3) != 0;
      fe_done = 1'b0; fe_ack = 1'b0; fe_rdata = 16'hFFFF;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          fe_done = 1'b1;
          fe_ack = (rsp_phy < NPHY) ? present[rsp_phy[1:0]] : 1'b0;
          if (rsp_reg == 5'd1)
            fe_rdata = 16'h7809 | (((rsp_phy < NPHY) ? 16'(link_up[rsp_phy[1:0]]) : 16'd0) << 2);
          else
            fe_rdata = 16'hA000 | {6'd0, rsp_phy, rsp_reg};
        end
      end
      #3;
      model_eval();
    end
  end

  task automatic do_user(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd);
    int waited;
    int seen0;
    seen0 = rsp_seen;
    @(negedge clk);
    usr_valid = 1'b1; usr_write = wr; usr_phy = phy; usr_reg = rg; usr_wdata = wd;
    waited = 0;
    #4;
    while (!usr_ready) begin
      @(negedge clk);
      waited++;
      #4;
    end
    @(negedge clk);
    usr_valid = 1'b0;
    check(waited <= 8, "R6 user wait bounded by one frame", 32'(waited), 32'd8);
    for (int k = 0; k < 20 && rsp_seen == seen0; k++) @(negedge clk);
    check(rsp_seen == seen0 + 1, "R12 one response per command", 32'(rsp_seen), 32'(seen0 + 1));
  endtask

  initial begin
    int w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #4;
    check(alive_mask == '0 && link_mask == '0 && link_irq_raw == '0, "R1 vectors after reset",
          {alive_mask, link_mask, link_irq_raw}, 32'd0);
    check(scan_idle && !fe_req_valid, "R1 idle after reset", {scan_idle, fe_req_valid}, 32'h2);

    @(negedge clk) scan_enable = 1'b1;
    repeat (60) @(negedge clk);
    #4;
    check(alive_mask == 4'b1101, "R3 presence after round", 32'(alive_mask), 32'hD);
    check(link_mask == 4'b1001, "R4 link after round", 32'(link_mask), 32'h9);
    check(link_irq_raw == 4'b1001, "R8 flags after first links", 32'(link_irq_raw), 32'h9);

    @(negedge clk) link_irq_en = 4'b0001;
    #4;
    check(link_irq_masked == 4'b0001, "R10 masked subset", 32'(link_irq_masked), 32'h1);

    @(negedge clk) link_irq_clr = 4'hF;
    @(negedge clk) link_irq_clr = 4'h0;
    #4;
    check(link_irq_raw == 4'b0000, "R9 write-1 clear", 32'(link_irq_raw), 32'h0);

    @(negedge clk) begin present[0] = 1'b0; link_up[3] = 1'b0; end
    repeat (40) @(negedge clk);
    #4;
    check(alive_mask[0] == 1'b0 && link_mask[0] == 1'b0, "R5 no-ack clears both",
          {alive_mask[0], link_mask[0]}, 32'h0);
    check(alive_mask == 4'b1100 && link_mask == 4'b0000, "R5 R4 vectors after loss",
          {alive_mask, link_mask}, 32'hC0);
    check(link_irq_raw == 4'b1001, "R8 flags after link drops", 32'(link_irq_raw), 32'h9);

    do_user(1'b0, 5'd2, 5'd7, 16'h0);
    check(last_ack == 1'b1 && last_rdata == 16'hA047, "R12 user read data",
          {last_ack, last_rdata}, 32'h1A047);
    do_user(1'b1, 5'd3, 5'd4, 16'h1234);
    check(last_ack == 1'b1, "R12 user write ack", 32'(last_ack), 32'h1);
    do_user(1'b0, 5'd1, 5'd2, 16'h0);
    check(last_ack == 1'b0, "R12 absent PHY no ack", 32'(last_ack), 32'h0);

    @(negedge clk) scan_enable = 1'b0;
    w = 0;
    #4;
    while (!scan_idle && w < 20) begin
      @(negedge clk); w++; #4;
    end
    check(scan_idle && w <= 8, "R11 idle after current frame", 32'(w), 32'd8);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #4;
      check(!fe_req_valid, "R11 no scan while disabled", 32'(fe_req_valid), 32'h0);
    end
    do_user(1'b0, 5'd3, 5'd9, 16'h0);
    check(last_rdata == 16'hA069, "R6 user served while disabled", 32'(last_rdata), 32'hA069);

    @(negedge clk) begin scan_enable = 1'b1; present[0] = 1'b1; link_up[0] = 1'b1; end
    repeat (40) @(negedge clk);
    #4;
    check(alive_mask == 4'b1101 && link_mask == 4'b0001, "R3 R4 recovery",
          {alive_mask, link_mask}, 32'hD1);
    check(link_irq_raw == 4'b1001, "R8 flag stays until cleared", 32'(link_irq_raw), 32'h9);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule